// File: doc/BRIEF.md
# Indirect Address/Data Access Gateway

This block lets a host reach a wider internal word space through three 32-bit registers in a small window. A control register picks one of several address spaces and reports whether that space exists and how large it is. An address register takes a request and, in its top bit, carries both the direction of the request and the completion handshake. A data register holds the write operand or the read result. Every request finishes a fixed number of cycles after it is accepted, against a modelled word array with one bank per space.

A write request is a store to the data register followed by a store to the address register with bit 31 set. The host then polls until bit 31 drops. A read request is a store to the address register with bit 31 clear. The host then polls until bit 31 rises and collects the data register. After a successful read, the address field holds the next address worth reading. This lets a host walk a sparse space without touching its holes. Bad requests complete with a syndrome bit and leave memory alone.

Top module: `gw_bridge`

## Requirements
- R1: Host offsets: control at 0x04, address at 0x10, data at 0x14. Every other offset reads zero. A read returns the current register value combinationally in the same cycle, and a store takes effect at the clock edge where `reg_wr` is high.
- R2: The control register holds the space number in bits 15:0, size-valid in bit 28 and status in bits 31:29. For a space number below NUM_SPACES (4), status reads 1 and size-valid reads 1. Otherwise both read 0. Bits 27:16 read zero, and reset selects space 0.
- R3: A control store that selects a supported space loads the address register with flag 0, syndrome 0 and bits 29:0 equal to the space's maximum byte address, (WORDS-1)*4 = 60. A control store that selects an unsupported space leaves the address register unchanged.
- R4: A write request is an address store with bit 31 = 1. Bit 31 reads back 1 for exactly LATENCY (3) cycles and then reads 0. At that point the data register value has been stored in the addressed word.
- R5: A read request is an address store with bit 31 = 0. Bit 31 reads back 0 for exactly LATENCY cycles and then reads 1. At that point the data register holds the addressed word.
- R6: Bits 29:0 of a request form a byte address, and the word index is the address divided by 4, with bits 1:0 ignored. Each space owns a separate bank of WORDS (16) words, and every bank is zero after reset.
- R7: After a successful read, address bits 29:0 hold the next readable address, which is always greater than the one just read. In even-numbered spaces (dense), this is (index+1)*4. In odd-numbered spaces (sparse), it is 4 times the smallest index above the current one that is a multiple of 3. If no such index exists, it is WORDS*4 = 64.
- R8: While a request is pending, host stores to the control, address and data registers are all ignored.
- R9: A request completes with syndrome (address bit 30) = 1 and does not access memory in three cases: its address exceeds 60, it had bit 30 set, or the selected space is unsupported. In that case the data register and the address field keep their values. A new request clears the syndrome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host store strobe |
| reg_off | input | 5 | Host register byte offset |
| reg_wdata | input | 32 | Host store data |
| reg_rdata | output | 32 | Host read data for `reg_off` |

## Verification
On every cycle, the assertions check four things: the flag direction at completion for reads and for writes, that the data register holds steady under stores while a request is pending, that an out-of-range access raises the syndrome, and that the read hint always moves forward. Only the bench scenarios can show the rest. These cover the exact busy duration seen by polling, the values that land in each bank, the sparse hint sequence through holes and at the end of a space, that bad requests leave memory untouched, and that banks stay isolated from each other.

// File: rtl/gw_bridge.sv
`timescale 1ns/1ps
module gw_bridge #(
  parameter int NUM_SPACES  = 4,
  parameter int WORDS       = 16,
  parameter int LATENCY     = 3,
  parameter int SPARSE_STEP = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_off,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  localparam int IW       = $clog2(WORDS);
  localparam int SW       = (NUM_SPACES > 1) ? $clog2(NUM_SPACES) : 1;
  localparam int CW       = $clog2(LATENCY + 1);
  localparam int DEPTH    = NUM_SPACES * WORDS;
  localparam int MAX_ADDR = (WORDS - 1) * 4;
  localparam logic [4:0] OFF_CTRL = 5'h04;
  localparam logic [4:0] OFF_ADDR = 5'h10;
  localparam logic [4:0] OFF_DATA = 5'h14;

  logic [15:0]   space_q;
  logic          flag_q, synd_q, bad_q, pend_q, op_wr_q;
  logic [29:0]   addr_q;
  logic [31:0]   data_q;
  logic [CW-1:0] cnt_q;
  logic [31:0]   mem [DEPTH];

  wire           supported = space_q < 16'(NUM_SPACES);
  wire           sparse    = space_q[0];
  wire [IW-1:0]  widx      = addr_q[IW+1:2];
  wire [SW+IW-1:0] midx    = {space_q[SW-1:0], widx};
  wire           in_range  = addr_q <= 30'(MAX_ADDR);
  wire           fault     = bad_q | ~supported | ~in_range;
  wire           accept    = reg_wr & ~pend_q;
  wire           done      = pend_q & (cnt_q == '0);

  function automatic logic [29:0] next_hint(input logic sp, input logic [IW-1:0] w);
    int n;
    n = WORDS;
    if (!sp) n = int'(w) + 1;
    else
      for (int j = WORDS - 1; j >= 0; j--)
        if (j > int'(w) && (j % SPARSE_STEP) == 0) n = j;
    return 30'(n * 4);
  endfunction

  always_comb begin
    case (reg_off)
      OFF_CTRL: reg_rdata = {supported ? 3'd1 : 3'd0, supported, 12'd0, space_q};
      OFF_ADDR: reg_rdata = {flag_q, synd_q, addr_q};
      OFF_DATA: reg_rdata = data_q;
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      space_q <= '0;
      flag_q  <= 1'b0;
      synd_q  <= 1'b0;
      bad_q   <= 1'b0;
      pend_q  <= 1'b0;
      op_wr_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (accept) begin
        case (reg_off)
          OFF_CTRL: begin
            space_q <= reg_wdata[15:0];
            if (reg_wdata[15:0] < 16'(NUM_SPACES)) begin
              addr_q <= 30'(MAX_ADDR);
              flag_q <= 1'b0;
              synd_q <= 1'b0;
            end
          end
          OFF_ADDR: begin
            addr_q  <= reg_wdata[29:0];
            flag_q  <= reg_wdata[31];
            op_wr_q <= reg_wdata[31];
            bad_q   <= reg_wdata[30];
            synd_q  <= 1'b0;
            pend_q  <= 1'b1;
            cnt_q   <= CW'(LATENCY - 1);
          end
          OFF_DATA: data_q <= reg_wdata;
          default: ;
        endcase
      end
      if (pend_q) begin
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else begin
          pend_q <= 1'b0;
          synd_q <= fault;
          flag_q <= ~op_wr_q;
          if (!fault) begin
            if (op_wr_q) mem[midx] <= data_q;
            else begin
              data_q <= mem[midx];
              addr_q <= next_hint(sparse, widx);
            end
          end
        end
      end
    end
  end

  // R4
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_wr_q |=> !flag_q);
  // R5
  rd_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !op_wr_q |=> flag_q);
  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !done && reg_wr && reg_off == OFF_DATA |=> $stable(data_q));
  // R9
  range_synd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !in_range |=> synd_q);
  // R7
  hint_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pend_q) && !pend_q && flag_q && !synd_q |-> addr_q > $past(addr_q));
endmodule

// File: tb/gw_bridge_test.sv
`timescale 1ns/1ps
module gw_bridge_test;
  localparam int LAT = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_off = 5'h04;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gw_bridge uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
                 .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // behavioural reference
  int m_space, m_addr, m_pend;
  bit m_flag, m_synd, m_bad, m_wr;
  logic [31:0] m_data;
  logic [31:0] m_mem [4][16];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_space = 0; m_addr = 0; m_pend = 0; m_flag = 0; m_synd = 0; m_bad = 0; m_wr = 0; m_data = 0;
      foreach (m_mem[s, w]) m_mem[s][w] = 0;
    end else begin
      bit busy;
      busy = m_pend > 0;
      if (busy) begin
        m_pend--;
        if (m_pend == 0) begin
          bit err;
          int w, nx;
          err = m_bad || m_space >= 4 || m_addr > 60;
          w = m_addr / 4;
          m_synd = err;
          m_flag = !m_wr;
          if (!err) begin
            if (m_wr) m_mem[m_space][w] = m_data;
            else begin
              m_data = m_mem[m_space][w];
              if (m_space % 2 == 0) nx = w + 1;
              else begin
                nx = 16;
                for (int j = 15; j > w; j--) if (j % 3 == 0) nx = j;
              end
              m_addr = nx * 4;
            end
          end
        end
      end
      if (reg_wr && !busy) begin
        if (reg_off == 5'h04) begin
          m_space = int'(reg_wdata[15:0]);
          if (m_space < 4) begin m_addr = 60; m_flag = 0; m_synd = 0; end
        end else if (reg_off == 5'h10) begin
          m_addr = int'(reg_wdata[29:0]); m_flag = reg_wdata[31]; m_wr = reg_wdata[31];
          m_bad = reg_wdata[30]; m_synd = 0; m_pend = LAT;
        end else if (reg_off == 5'h14) m_data = reg_wdata;
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [4:0] o);
    if (o == 5'h04) return (m_space < 4) ? (32'h3000_0000 | 32'(m_space)) : 32'(m_space);
    if (o == 5'h10) return {m_flag, m_synd, 30'(m_addr)};
    if (o == 5'h14) return m_data;
    return 32'd0;
  endfunction

  function automatic string tag_of(input logic [4:0] o);
    if (o == 5'h04) return "R2";
    if (o == 5'h10) return "R7";
    if (o == 5'h14) return "R5";
    return "R1";
  endfunction

  task automatic compare_model();
    logic [31:0] e;
    e = model_rd(reg_off);
    n_cmp++;
    if (reg_rdata !== e) begin
      n_bad++;
      $display("FAIL %s cycle compare off=%h actual=%h expected=%h", tag_of(reg_off), reg_off, reg_rdata, e);
    end
  endtask

  task automatic step(input logic w, input logic [4:0] o, input logic [31:0] d);
    reg_wr = w; reg_off = o; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    compare_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, reg_off, 32'd0);
  endtask

  task automatic chk(input logic [4:0] o, input logic [31:0] e, input string tag);
    reg_off = o;
    #1;
    n_cmp++;
    if (reg_rdata !== e) begin
      n_bad++;
      $display("FAIL %s off=%h actual=%h expected=%h", tag, o, reg_rdata, e);
    end
  endtask

  task automatic req(input logic [31:0] a);
    step(1'b1, 5'h10, a);
    idle(LAT);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(5'h04, 32'h3000_0000, "R2 reset");
    chk(5'h10, 32'h0, "R1 addr reset");
    chk(5'h08, 32'h0, "R1 unmapped");
    step(1'b1, 5'h08, 32'hFFFF_FFFF);
    chk(5'h08, 32'h0, "R1 unmapped store");

    step(1'b1, 5'h04, 32'd7);
    chk(5'h04, 32'h0000_0007, "R2 unsupported");
    chk(5'h10, 32'h0, "R3 unchanged");
    step(1'b1, 5'h04, 32'd0);
    chk(5'h10, 32'h0000_003C, "R3 max addr");

    step(1'b1, 5'h14, 32'hA5A5_0001);
    step(1'b1, 5'h10, 32'h8000_0008);
    chk(5'h10, 32'h8000_0008, "R4 busy");
    idle(LAT - 1);
    chk(5'h10, 32'h8000_0008, "R4 busy last");
    idle(1);
    chk(5'h10, 32'h0000_0008, "R4 done");

    step(1'b1, 5'h10, 32'h0000_000A);
    chk(5'h10, 32'h0000_000A, "R5 busy");
    step(1'b1, 5'h14, 32'hDEAD_BEEF);
    step(1'b1, 5'h10, 32'h8000_0000);
    step(1'b1, 5'h04, 32'd3);
    chk(5'h10, 32'h8000_000C, "R7 dense hint");
    chk(5'h14, 32'hA5A5_0001, "R5 data");
    chk(5'h04, 32'h3000_0000, "R8 ctrl ignored");

    step(1'b1, 5'h04, 32'd1);
    step(1'b1, 5'h14, 32'h0000_1111);
    req(32'h8000_000C);
    req(32'h0000_0000);
    chk(5'h10, 32'h8000_000C, "R7 sparse hint 0");
    chk(5'h14, 32'h0, "R6 zero bank");
    req(32'h0000_000C);
    chk(5'h14, 32'h0000_1111, "R6 sparse word");
    chk(5'h10, 32'h8000_0018, "R7 sparse hint 12");
    req(32'h0000_002C);
    chk(5'h10, 32'h8000_0030, "R7 sparse hint 44");
    req(32'h0000_003C);
    chk(5'h10, 32'h8000_0040, "R7 sparse end");

    step(1'b1, 5'h14, 32'h0000_5555);
    req(32'h0000_0040);
    chk(5'h10, 32'hC000_0040, "R9 read range");
    chk(5'h14, 32'h0000_5555, "R9 data kept");
    step(1'b1, 5'h14, 32'h0000_7777);
    req(32'h8000_0064);
    chk(5'h10, 32'h4000_0064, "R9 write range");
    step(1'b1, 5'h14, 32'h0000_9999);
    req(32'hC000_0000);
    chk(5'h10, 32'h4000_0000, "R9 bit30");
    req(32'h0000_0000);
    chk(5'h14, 32'h0, "R9 memory untouched");
    chk(5'h10, 32'h8000_000C, "R9 synd cleared");

    step(1'b1, 5'h04, 32'd5);
    req(32'h0000_0000);
    chk(5'h10, 32'hC000_0000, "R9 unsupported space");
    chk(5'h04, 32'h0000_0005, "R2 unsupported read");

    step(1'b1, 5'h04, 32'd2);
    step(1'b1, 5'h14, 32'h0000_BEEF);
    req(32'h8000_0008);
    req(32'h0000_003C);
    chk(5'h10, 32'h8000_0040, "R7 dense end");
    req(32'h0000_0008);
    chk(5'h14, 32'h0000_BEEF, "R6 bank 2");
    step(1'b1, 5'h04, 32'd0);
    req(32'h0000_0008);
    chk(5'h14, 32'hA5A5_0001, "R6 bank 0 isolated");

    idle(4);
    summary();
    $finish;
  end
endmodule